// File: doc/BRIEF.md
# Multi-Mode ADC Conversion Sequencer

This block schedules conversions for a converter that sits behind a four-way analog multiplexer. Software writes a 6-bit mode code, a starting channel and two 5-bit timing fields. The sequencer then steps each conversion through three phases: an optional warm-up phase, a sampling (acquisition) phase and a fixed conversion phase. It times these phases by counting a one-cycle microsecond tick. While a conversion runs, the block drives the multiplexer select. It pulses a sample strobe when acquisition ends. When conversion ends, it captures the 12-bit converter output and pulses the write strobe for that channel's result slot.

The manual modes run either one conversion or one pass over all four inputs, and then fall back to the awake state. The automatic modes keep converting until the mode changes. The scan variants rotate through the inputs, starting at the selected channel. A new active mode is taken only from the awake state, so every change between active modes passes through awake. Writing the idle code stops all activity at once. The first conversion after leaving idle includes the warm-up phase.

Control and result pins are plain pins, with no valid/ready handshake. The converter timing is fixed by the tick, so the result-slot writes are single-cycle strobes that cannot be back-pressured. A slot that cannot be written in that cycle loses the result.

Top module: `adcseq_top`

## Requirements
- R1: Mode codes are 0x00 idle, 0x20 awake, 0x30 manual-single, 0x32 manual-scan, 0x31 auto-single, 0x33 auto-scan, 0x39 auto-single-with-sleep, 0x3B auto-scan-with-sleep and 0x3F auto-burst-with-sleep. Idle and awake are accepted from any state. Any other code is ignored and leaves `mode_q` unchanged.
- R2: An active code is accepted only while `mode_q` is awake. Writing it from idle or from another active mode leaves `mode_q` unchanged.
- R3: Writing idle forces `mux_en` low on the next cycle. It also suppresses any sample or write strobe at that edge, and the next conversion then includes the warm-up phase.
- R4: Acquisition lasts (2 × `acq_time` + 6) ticks. `sample_strobe` pulses for one cycle at its end.
- R5: Conversion lasts 4 ticks. At its end, `res_wr` pulses one-hot (bit n for channel n) and `res_data` takes `conv_result`, holding it until the next write.
- R6: Warm-up lasts 2 × `pu_time` ticks. It runs only in the first conversion after idle is left, and it is skipped when `pu_time` is 0.
- R7: Manual-single performs one conversion on the channel captured when the mode was accepted, and then `mode_q` returns to awake.
- R8: Manual-scan converts four channels, starting at the captured channel and wrapping modulo 4, and then `mode_q` returns to awake.
- R9: The auto modes repeat without stopping. The sleep variants behave as their base mode, and burst behaves as scan.
- R10: `mux_en` is high only while a phase is running. `mux_sel` then names the channel being converted.
- R11: After reset, `mode_q` is idle, `mux_en` is low, there are no strobes and `res_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| mode_wr | input | 1 | Write strobe for `mode_val` |
| mode_val | input | 6 | Requested mode code |
| chan_sel | input | 2 | Start channel, captured on acceptance |
| acq_time | input | 5 | Acquisition time field |
| pu_time | input | 5 | Warm-up time field |
| conv_result | input | 12 | Converter output |
| mode_q | output | 6 | Current mode code |
| mux_en | output | 1 | Multiplexer enabled, phase running |
| mux_sel | output | 2 | Selected input channel |
| sample_strobe | output | 1 | End of acquisition |
| res_wr | output | 4 | One-hot result-slot write strobe |
| res_data | output | 12 | Result written to the slot |

## Verification
The assertions check several rules on every cycle:
- an active mode is only ever entered from awake;
- an idle write always drops the multiplexer on the next cycle;
- write strobes are one-hot and only follow a running conversion;
- conversion is entered only from acquisition.

The exact phase lengths in ticks, the warm-up running only after idle, the rotation order of scans and the return to awake after a manual pass can only be shown by the bench's scenarios. There, a behavioural model is compared against the outputs on every clock.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  localparam int MODE_W = 6;

  localparam logic [MODE_W-1:0] M_IDLE       = 6'h00;
  localparam logic [MODE_W-1:0] M_AWAKE      = 6'h20;
  localparam logic [MODE_W-1:0] M_MAN_ONE    = 6'h30;
  localparam logic [MODE_W-1:0] M_MAN_SCAN   = 6'h32;
  localparam logic [MODE_W-1:0] M_AUTO_ONE   = 6'h31;
  localparam logic [MODE_W-1:0] M_AUTO_SCAN  = 6'h33;
  localparam logic [MODE_W-1:0] M_AUTO_ONE_S = 6'h39;
  localparam logic [MODE_W-1:0] M_AUTO_SCN_S = 6'h3B;
  localparam logic [MODE_W-1:0] M_BURST_S    = 6'h3F;

  typedef enum logic [1:0] {PH_NONE, PH_PWRUP, PH_ACQ, PH_CONV} phase_e;

  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    case (m)
      M_MAN_ONE, M_MAN_SCAN, M_AUTO_ONE, M_AUTO_SCAN,
      M_AUTO_ONE_S, M_AUTO_SCN_S, M_BURST_S: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic mode_scan(input logic [MODE_W-1:0] m);
    case (m)
      M_MAN_SCAN, M_AUTO_SCAN, M_AUTO_SCN_S, M_BURST_S: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic mode_manual(input logic [MODE_W-1:0] m);
    return (m == M_MAN_ONE) || (m == M_MAN_SCAN);
  endfunction

endpackage

// File: rtl/adcseq_mode_ctrl.sv
module adcseq_mode_ctrl
  import adcseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_val,
  input  logic              pass_done,
  output logic [MODE_W-1:0] mode_q,
  output logic              restart,
  output logic              go_idle,
  output logic              load_active,
  output logic              run
);

  logic accept;

  always_comb begin
    accept = 1'b0;
    if (mode_wr) begin
      if (mode_val == M_IDLE || mode_val == M_AWAKE)
        accept = 1'b1;
      else if (mode_active(mode_val) && mode_q == M_AWAKE)
        accept = 1'b1;
    end
  end

  assign restart     = accept;
  assign go_idle     = accept && (mode_val == M_IDLE);
  assign load_active = accept && mode_active(mode_val);
  assign run         = mode_active(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= M_IDLE;
    else if (accept)
      mode_q <= mode_val;
    else if (pass_done)
      mode_q <= M_AWAKE;
  end

  AST_ACTIVE_FROM_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_active(mode_q) && mode_q != $past(mode_q)) |-> $past(mode_q) == M_AWAKE); // R2

endmodule

// File: rtl/adcseq_phase_timer.sv
module adcseq_phase_timer
  import adcseq_pkg::*;
#(
  parameter int TIME_W      = 5,
  parameter int STEP_US     = 2,
  parameter int ACQ_BASE_US = 6,
  parameter int CONV_US     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              run,
  input  logic              restart,
  input  logic              go_idle,
  input  logic [TIME_W-1:0] acq_time,
  input  logic [TIME_W-1:0] pu_time,
  output phase_e            phase,
  output logic              acq_done,
  output logic              conv_done
);

  localparam int MAX_LEN = STEP_US * (2**TIME_W - 1) + ACQ_BASE_US;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_len;
  logic             pu_pend;
  logic             last;

  always_comb begin
    case (phase)
      PH_PWRUP: cur_len = CNT_W'(pu_time) * CNT_W'(STEP_US);
      PH_ACQ:   cur_len = CNT_W'(acq_time) * CNT_W'(STEP_US) + CNT_W'(ACQ_BASE_US);
      PH_CONV:  cur_len = CNT_W'(CONV_US);
      default:  cur_len = '0;
    endcase
  end

  assign last      = us_tick && (phase != PH_NONE) && (cnt == cur_len - CNT_W'(1));
  assign acq_done  = !restart && last && (phase == PH_ACQ);
  assign conv_done = !restart && last && (phase == PH_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_NONE;
      cnt     <= '0;
      pu_pend <= 1'b1;
    end else if (restart) begin
      phase <= PH_NONE;
      cnt   <= '0;
      if (go_idle) pu_pend <= 1'b1;
    end else begin
      case (phase)
        PH_NONE: begin
          if (run) begin
            phase   <= (pu_pend && pu_time != '0) ? PH_PWRUP : PH_ACQ;
            pu_pend <= 1'b0;
            cnt     <= '0;
          end
        end
        default: begin
          if (us_tick) begin
            if (last) begin
              cnt <= '0;
              case (phase)
                PH_PWRUP: phase <= PH_ACQ;
                PH_ACQ:   phase <= PH_CONV;
                default:  phase <= PH_NONE;
              endcase
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  AST_CONV_AFTER_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV && $past(phase) != PH_CONV) |-> $past(phase) == PH_ACQ); // R4

endmodule

// File: rtl/adcseq_chan_ctrl.sv
module adcseq_chan_ctrl
  import adcseq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 12,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              load_active,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic [MODE_W-1:0] mode_q,
  input  logic              acq_done,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic [CH_W-1:0]   ch,
  output logic              pass_done,
  output logic              sample_strobe,
  output logic [NUM_CH-1:0] res_wr,
  output logic [RES_W-1:0]  res_data
);

  logic [CH_W-1:0]   idx;
  logic [NUM_CH-1:0] wr_vec;
  logic [CH_W-1:0]   ch_next;
  logic              scan;

  assign scan    = mode_scan(mode_q);
  assign ch_next = (ch == CH_W'(NUM_CH - 1)) ? '0 : ch + CH_W'(1);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_wr
    assign wr_vec[i] = conv_done && (ch == CH_W'(i));
  end

  assign pass_done = conv_done && mode_manual(mode_q) &&
                     (!scan || idx == CH_W'(NUM_CH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch            <= '0;
      idx           <= '0;
      sample_strobe <= 1'b0;
      res_wr        <= '0;
      res_data      <= '0;
    end else if (restart) begin
      sample_strobe <= 1'b0;
      res_wr        <= '0;
      if (load_active) begin
        ch  <= chan_sel;
        idx <= '0;
      end
    end else begin
      sample_strobe <= acq_done;
      res_wr        <= wr_vec;
      if (conv_done) begin
        res_data <= conv_result;
        if (scan) begin
          ch  <= ch_next;
          idx <= idx + CH_W'(1);
        end
      end
    end
  end

  AST_NO_SAMPLE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_strobe && (|res_wr))); // R5

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int RES_W       = 12,
  parameter int TIME_W      = 5,
  parameter int STEP_US     = 2,
  parameter int ACQ_BASE_US = 6,
  parameter int CONV_US     = 4,
  localparam int CH_W       = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              mode_wr,
  input  logic [5:0]        mode_val,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic [TIME_W-1:0] acq_time,
  input  logic [TIME_W-1:0] pu_time,
  input  logic [RES_W-1:0]  conv_result,
  output logic [5:0]        mode_q,
  output logic              mux_en,
  output logic [CH_W-1:0]   mux_sel,
  output logic              sample_strobe,
  output logic [NUM_CH-1:0] res_wr,
  output logic [RES_W-1:0]  res_data
);

  logic   restart, go_idle, load_active, run, pass_done;
  logic   acq_done, conv_done;
  phase_e phase;

  adcseq_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
    .pass_done(pass_done), .mode_q(mode_q), .restart(restart),
    .go_idle(go_idle), .load_active(load_active), .run(run)
  );

  adcseq_phase_timer #(
    .TIME_W(TIME_W), .STEP_US(STEP_US), .ACQ_BASE_US(ACQ_BASE_US), .CONV_US(CONV_US)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .run(run), .restart(restart),
    .go_idle(go_idle), .acq_time(acq_time), .pu_time(pu_time), .phase(phase),
    .acq_done(acq_done), .conv_done(conv_done)
  );

  adcseq_chan_ctrl #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .restart(restart), .load_active(load_active),
    .chan_sel(chan_sel), .mode_q(mode_q), .acq_done(acq_done),
    .conv_done(conv_done), .conv_result(conv_result), .ch(mux_sel),
    .pass_done(pass_done), .sample_strobe(sample_strobe), .res_wr(res_wr),
    .res_data(res_data)
  );

  assign mux_en = (phase != PH_NONE);

  AST_IDLE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_val == M_IDLE) |=> (!mux_en && !sample_strobe && res_wr == '0)); // R3
  AST_MUX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_IDLE) |-> !mux_en); // R10
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_wr)); // R5
  AST_WR_AFTER_MUX: assert property (@(posedge clk) disable iff (!rst_n)
    (|res_wr) |-> $past(mux_en)); // R5

endmodule

// File: tb/adcseq_top_bench.sv
module adcseq_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        us_tick = 1'b0;
  logic        mode_wr = 1'b0;
  logic [5:0]  mode_val = '0;
  logic [1:0]  chan_sel = '0;
  logic [4:0]  acq_time = '0;
  logic [4:0]  pu_time = '0;
  logic [11:0] conv_result = '0;
  logic [5:0]  mode_q;
  logic        mux_en;
  logic [1:0]  mux_sel;
  logic        sample_strobe;
  logic [3:0]  res_wr;
  logic [11:0] res_data;

  always #10 clk = ~clk;

  adcseq_top u_adcseq_top (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .mode_wr(mode_wr),
    .mode_val(mode_val), .chan_sel(chan_sel), .acq_time(acq_time),
    .pu_time(pu_time), .conv_result(conv_result), .mode_q(mode_q),
    .mux_en(mux_en), .mux_sel(mux_sel), .sample_strobe(sample_strobe),
    .res_wr(res_wr), .res_data(res_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  int m_mode, m_phase, m_cnt, m_ch, m_idx, m_pu_pend, m_sample, m_wr, m_data;
  int tcnt = 0;
  int wq[$];

  function automatic bit is_act(int m);
    return m == 'h30 || m == 'h32 || m == 'h31 || m == 'h33 ||
           m == 'h39 || m == 'h3B || m == 'h3F;
  endfunction
  function automatic bit is_scan(int m);
    return m == 'h32 || m == 'h33 || m == 'h3B || m == 'h3F;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit acc;
    int len;
    acc = mode_wr && (mode_val == 6'h00 || mode_val == 6'h20 ||
                      (is_act(int'(mode_val)) && m_mode == 'h20));
    m_sample = 0;
    m_wr = 0;
    if (acc) begin
      m_mode = int'(mode_val);
      m_phase = 0;
      m_cnt = 0;
      if (mode_val == 6'h00) m_pu_pend = 1;
      if (is_act(m_mode)) begin m_ch = int'(chan_sel); m_idx = 0; end
    end else if (m_phase == 0) begin
      if (is_act(m_mode)) begin
        m_phase = (m_pu_pend != 0 && pu_time != 0) ? 1 : 2;
        m_pu_pend = 0;
        m_cnt = 0;
      end
    end else if (us_tick) begin
      len = (m_phase == 1) ? 2 * int'(pu_time) :
            (m_phase == 2) ? 2 * int'(acq_time) + 6 : 4;
      if (m_cnt == len - 1) begin
        m_cnt = 0;
        if (m_phase == 1) m_phase = 2;
        else if (m_phase == 2) begin m_phase = 3; m_sample = 1; end
        else begin
          bit fin;
          m_phase = 0;
          m_wr = 1 << m_ch;
          m_data = int'(conv_result);
          fin = (m_mode == 'h30) || (m_mode == 'h32 && m_idx == 3);
          if (is_scan(m_mode)) begin m_ch = (m_ch + 1) % 4; m_idx = (m_idx + 1) % 4; end
          if (fin) m_mode = 'h20;
        end
      end else m_cnt++;
    end
  endtask

  task automatic compare();
    chk("R2 mode", int'(mode_q), m_mode);
    chk("R10 mux_en", int'(mux_en), (m_phase != 0) ? 1 : 0);
    if (mux_en) chk("R10 mux_sel", int'(mux_sel), m_ch);
    chk("R4 R6 R9 sample", int'(sample_strobe), m_sample);
    chk("R5 res_wr", int'(res_wr), m_wr);
    chk("R5 res_data", int'(res_data), m_data);
    for (int i = 0; i < 4; i++) if (res_wr[i]) wq.push_back(i);
  endtask

  // one clock: tick and converter stub driven, model stepped, outputs compared
  task automatic cyc(int n);
    for (int k = 0; k < n; k++) begin
      us_tick = (tcnt % 3 == 0);
      tcnt++;
      conv_result = {mux_sel, 10'(tcnt)};
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
      mode_wr = 1'b0;
    end
  endtask

  task automatic wr_mode(logic [5:0] v, logic [1:0] c);
    mode_val = v;
    chan_sel = c;
    mode_wr = 1'b1;
    cyc(1);
  endtask

  task automatic run_until_awake(int limit);
    for (int k = 0; k < limit; k++) begin
      if (mode_q == 6'h20) break;
      cyc(1);
    end
  endtask

  initial begin
    m_mode = 0; m_phase = 0; m_cnt = 0; m_ch = 0; m_idx = 0;
    m_pu_pend = 1; m_sample = 0; m_wr = 0; m_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 mode", int'(mode_q), 0);
    chk("R11 mux_en", int'(mux_en), 0);
    chk("R11 strobes", int'({sample_strobe, res_wr}), 0);
    chk("R11 data", int'(res_data), 0);
    cyc(2);

    // R2: active straight from idle is ignored
    wr_mode(6'h30, 2'd0);
    cyc(2);
    chk("R2 from idle", int'(mode_q), 0);
    // R1: unknown code ignored
    wr_mode(6'h15, 2'd0);
    chk("R1 bad code", int'(mode_q), 0);

    // R7 R6: manual single after idle, warm-up 2
    pu_time = 5'd2; acq_time = 5'd1;
    wr_mode(6'h20, 2'd0);
    wq.delete();
    wr_mode(6'h30, 2'd1);
    run_until_awake(400);
    cyc(3);
    chk("R7 back to awake", int'(mode_q), 'h20);
    chk("R7 one write", wq.size(), 1);
    if (wq.size() > 0) chk("R7 channel", wq[0], 1);

    // R8: manual scan from channel 2, no warm-up now
    acq_time = 5'd0;
    wq.delete();
    wr_mode(6'h32, 2'd2);
    run_until_awake(1000);
    cyc(2);
    chk("R8 four writes", wq.size(), 4);
    if (wq.size() == 4) begin
      chk("R8 order0", wq[0], 2);
      chk("R8 order1", wq[1], 3);
      chk("R8 order2", wq[2], 0);
      chk("R8 order3", wq[3], 1);
    end

    // R9 auto scan, then R2 direct switch ignored
    wq.delete();
    wr_mode(6'h33, 2'd3);
    cyc(400);
    chk("R9 repeats", (wq.size() > 4) ? 1 : 0, 1);
    chk("R9 still auto", int'(mode_q), 'h33);
    wr_mode(6'h31, 2'd0);
    chk("R2 active to active", int'(mode_q), 'h33);
    cyc(20);

    // R3: idle abort mid-run
    wr_mode(6'h00, 2'd0);
    chk("R3 mux off", int'(mux_en), 0);
    cyc(5);

    // R6 skipped with pu_time 0, auto single with sleep
    pu_time = 5'd0;
    wr_mode(6'h20, 2'd0);
    wr_mode(6'h39, 2'd2);
    cyc(150);

    // burst, then awake stops it, warm-up reappears after idle
    wr_mode(6'h20, 2'd0);
    wr_mode(6'h3F, 2'd1);
    cyc(200);
    wr_mode(6'h00, 2'd0);
    pu_time = 5'd3;
    wr_mode(6'h20, 2'd0);
    wr_mode(6'h3B, 2'd0);
    cyc(250);
    wr_mode(6'h00, 2'd0);
    cyc(5);
    chk("R3 idle final", int'(mux_en), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule